// File: doc/BRIEF.md
# Pin-Sharing Test Mode Selector

This block chooses one of eight operating modes from three mode pins and steers shared chip pins and internal multiplexers to match. Seven of the modes isolate one subsystem so it can be tested from the pins. The eighth mode runs the whole image pipeline. Outside the memory-test modes, the input and output frame buffers take their address, write strobe and write data from the on-chip controllers. In a buffer test, the selected buffer is driven entirely from pins. The data pins then form the low part of the address, and spare pins that are otherwise idle supply the upper part.

In the filter-core test, the core is cut off from its working memory. Pixels enter and leave the core over one shared data bus. The bus output-enable is raised only while the core reports a valid output, so the chip never drives against the tester. In the pad-check mode, an input pad is looped through an inverter to an output pad, and the internal clock is echoed out.

The mode pins pass through a two-flop synchronizer. A new mode is adopted only while the rest of the system is held in reset, so the steering never changes under a running pipeline.

Top module: `pin_mode_steer`

## Requirements
- R1: After reset, `modeCode` is 7 (full system), `isolateOneHot` is 8'h80 and `busOe` is 0.
- R2: While `holdReset` is 1, a value placed on `modePins` appears on `modeCode` after the third rising clock edge.
- R3: While `holdReset` is 0, changes on `modePins` leave `modeCode` unchanged.
- R4: `isolateOneHot` has exactly one bit set, at bit position `modeCode`. The codes are: 0 pad check, 1 input buffer test, 2 output buffer test, 3 filter core test, 4 filter loop test, 5 preprocessing test, 6 shift register test, 7 full system.
- R5: In mode 0, `padInvOut` equals the inverse of `padInvIn` and `clkEcho` follows `clk`. In every other mode, both are 0.
- R6: In mode 1, buffer 0 is driven from pins, and in mode 2, buffer 1 is driven from pins. The pin-driven buffer gets address `{spareAddrPins, dataPins}` (data pins in the low bits), its write enable equals `memWritePin`, and its write data equals `dataPins`.
- R7: Any buffer not selected under R6 passes its internal address, write enable and write data through unchanged.
- R8: In mode 3, `coreInPixel` equals `busIn`, `busOut` equals `coreOutPixel`, and `busOe` equals `coreOutValid`.
- R9: Outside mode 3, `busOe` is 0 and `coreInPixel` equals `workPixel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdReset | input | 1 | High while the rest of the system is held in reset; the mode may change only then |
| modePins | input | 3 | Mode select pins |
| modeCode | output | 3 | Adopted mode |
| isolateOneHot | output | 8 | One-hot subsystem select, one bit per mode |
| padInvIn | input | 1 | Pad-check inverter input pin |
| padInvOut | output | 1 | Pad-check inverter output pin |
| clkEcho | output | 1 | Clock echo pin |
| dataPins | input | 8 | Shared data pins |
| spareAddrPins | input | 6 | Idle pins used as upper address bits in buffer tests |
| memWritePin | input | 1 | Write strobe pin for buffer tests |
| bufAddrInt | input | 2x14 | Internal addresses (index 0 input buffer, 1 output buffer) |
| bufWeInt | input | 2 | Internal write enables |
| bufWrDataInt | input | 2x8 | Internal write data |
| bufAddr | output | 2x14 | Address to each buffer |
| bufWe | output | 2 | Write enable to each buffer |
| bufWrData | output | 2x8 | Write data to each buffer |
| busIn | input | 8 | Shared bus value seen from the pins |
| busOut | output | 8 | Value the chip drives onto the shared bus |
| busOe | output | 1 | Shared bus output-enable |
| coreOutValid | input | 1 | Filter core output-valid |
| coreOutPixel | input | 8 | Filter core output pixel |
| workPixel | input | 8 | Pixel from working memory |
| coreInPixel | output | 8 | Pixel fed to the filter core |

## Verification
The mode path has three registers between the pins and `modeCode` (two synchronizer flops and the adopting register). The bench therefore holds a new code on the pins for three rising edges with `holdReset` high, and then samples on the following falling edge. Every steering result (buffer address, write enable and data, bus enable, core input, pad inverter) is combinational from `modeCode` and the data inputs. So within a settled mode, the bench changes those inputs on a falling edge and samples one time unit later, in the same cycle. The clock echo is sampled just after a rising edge and just after a falling edge, to see both levels. For the ignore case, the bench waits several edges after the pins move before it reads `modeCode`.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int MODE_W = 3;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int NUM_BUF = 2;

  typedef enum logic [MODE_W-1:0] {
    M_PAD   = 3'd0,
    M_INBUF = 3'd1,
    M_OUTBUF= 3'd2,
    M_CORE  = 3'd3,
    M_LOOP  = 3'd4,
    M_PREP  = 3'd5,
    M_SHIFT = 3'd6,
    M_FULL  = 3'd7
  } mode_t;

  typedef struct packed {
    logic padCheck;
    logic inBufExt;
    logic outBufExt;
    logic coreBus;
    logic loopRun;
    logic prepRun;
    logic shiftRun;
    logic fullRun;
  } strobe_t;
endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 holdReset,
  input  logic [MODE_W-1:0]    modePins,
  output logic [MODE_W-1:0]    modeCode,
  output logic [NUM_MODES-1:0] isolateOneHot,
  output strobe_t              strobes
);
  logic [MODE_W-1:0] syncA, syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= M_FULL;
      syncB    <= M_FULL;
      modeCode <= M_FULL;
    end else begin
      syncA <= modePins;
      syncB <= syncA;
      if (holdReset) modeCode <= syncB;
    end
  end

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_onehot
    assign isolateOneHot[m] = (modeCode == MODE_W'(m));
  end

  always_comb begin
    strobes = '0;
    case (mode_t'(modeCode))
      M_PAD:    strobes.padCheck  = 1'b1;
      M_INBUF:  strobes.inBufExt  = 1'b1;
      M_OUTBUF: strobes.outBufExt = 1'b1;
      M_CORE:   strobes.coreBus   = 1'b1;
      M_LOOP:   strobes.loopRun   = 1'b1;
      M_PREP:   strobes.prepRun   = 1'b1;
      M_SHIFT:  strobes.shiftRun  = 1'b1;
      default:  strobes.fullRun   = 1'b1;
    endcase
  end
endmodule

// File: rtl/pms_data.sv
module pms_data
  import pms_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 14
) (
  input  logic                          clk,
  input  strobe_t                       strobes,
  input  logic                          padInvIn,
  output logic                          padInvOut,
  output logic                          clkEcho,
  input  logic [DW-1:0]                 dataPins,
  input  logic [AW-DW-1:0]              spareAddrPins,
  input  logic                          memWritePin,
  input  logic [NUM_BUF-1:0][AW-1:0]    bufAddrInt,
  input  logic [NUM_BUF-1:0]            bufWeInt,
  input  logic [NUM_BUF-1:0][DW-1:0]    bufWrDataInt,
  output logic [NUM_BUF-1:0][AW-1:0]    bufAddr,
  output logic [NUM_BUF-1:0]            bufWe,
  output logic [NUM_BUF-1:0][DW-1:0]    bufWrData,
  input  logic [DW-1:0]                 busIn,
  output logic [DW-1:0]                 busOut,
  output logic                          busOe,
  input  logic                          coreOutValid,
  input  logic [DW-1:0]                 coreOutPixel,
  input  logic [DW-1:0]                 workPixel,
  output logic [DW-1:0]                 coreInPixel
);
  logic [NUM_BUF-1:0] extSel;
  logic [AW-1:0]      pinAddr;

  assign extSel  = {strobes.outBufExt, strobes.inBufExt};
  assign pinAddr = {spareAddrPins, dataPins};

  assign padInvOut = strobes.padCheck & ~padInvIn;
  assign clkEcho   = strobes.padCheck & clk;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    always_comb begin
      if (extSel[b]) begin
        bufAddr[b]   = pinAddr;
        bufWe[b]     = memWritePin;
        bufWrData[b] = dataPins;
      end else begin
        bufAddr[b]   = bufAddrInt[b];
        bufWe[b]     = bufWeInt[b];
        bufWrData[b] = bufWrDataInt[b];
      end
    end
  end

  assign busOut      = coreOutPixel;
  assign busOe       = strobes.coreBus & coreOutValid;
  assign coreInPixel = strobes.coreBus ? busIn : workPixel;
endmodule

// File: rtl/pin_mode_steer.sv
module pin_mode_steer
  import pms_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 14
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          holdReset,
  input  logic [MODE_W-1:0]             modePins,
  output logic [MODE_W-1:0]             modeCode,
  output logic [NUM_MODES-1:0]          isolateOneHot,
  input  logic                          padInvIn,
  output logic                          padInvOut,
  output logic                          clkEcho,
  input  logic [DW-1:0]                 dataPins,
  input  logic [AW-DW-1:0]              spareAddrPins,
  input  logic                          memWritePin,
  input  logic [NUM_BUF-1:0][AW-1:0]    bufAddrInt,
  input  logic [NUM_BUF-1:0]            bufWeInt,
  input  logic [NUM_BUF-1:0][DW-1:0]    bufWrDataInt,
  output logic [NUM_BUF-1:0][AW-1:0]    bufAddr,
  output logic [NUM_BUF-1:0]            bufWe,
  output logic [NUM_BUF-1:0][DW-1:0]    bufWrData,
  input  logic [DW-1:0]                 busIn,
  output logic [DW-1:0]                 busOut,
  output logic                          busOe,
  input  logic                          coreOutValid,
  input  logic [DW-1:0]                 coreOutPixel,
  input  logic [DW-1:0]                 workPixel,
  output logic [DW-1:0]                 coreInPixel
);
  strobe_t strobes;

  pms_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .holdReset(holdReset), .modePins(modePins),
    .modeCode(modeCode), .isolateOneHot(isolateOneHot), .strobes(strobes)
  );

  pms_data #(.DW(DW), .AW(AW)) u_data (
    .clk(clk), .strobes(strobes),
    .padInvIn(padInvIn), .padInvOut(padInvOut), .clkEcho(clkEcho),
    .dataPins(dataPins), .spareAddrPins(spareAddrPins), .memWritePin(memWritePin),
    .bufAddrInt(bufAddrInt), .bufWeInt(bufWeInt), .bufWrDataInt(bufWrDataInt),
    .bufAddr(bufAddr), .bufWe(bufWe), .bufWrData(bufWrData),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .coreOutValid(coreOutValid), .coreOutPixel(coreOutPixel),
    .workPixel(workPixel), .coreInPixel(coreInPixel)
  );
endmodule

// File: rtl/pin_mode_steer_chk.sv
module pin_mode_steer_chk
  import pms_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 holdReset,
  input logic [MODE_W-1:0]    modeCode,
  input logic [NUM_MODES-1:0] isolateOneHot,
  input logic                 padInvOut,
  input logic                 busOe,
  input logic                 coreOutValid,
  input logic [DW-1:0]        busIn,
  input logic [DW-1:0]        coreInPixel
);
  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(holdReset) |-> $stable(modeCode));

  p_onehot_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(isolateOneHot) == 1) && isolateOneHot[modeCode]);

  p_pad_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode != M_PAD) |-> !padInvOut);

  p_bus_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == M_CORE && coreOutValid) |-> busOe);

  p_core_from_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == M_CORE) |-> (coreInPixel == busIn));

  p_bus_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (modeCode == M_CORE && coreOutValid));
endmodule

bind pin_mode_steer pin_mode_steer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .holdReset(holdReset), .modeCode(modeCode),
  .isolateOneHot(isolateOneHot), .padInvOut(padInvOut), .busOe(busOe),
  .coreOutValid(coreOutValid), .busIn(busIn), .coreInPixel(coreInPixel)
);

// File: tb/pin_mode_steer_bench.sv
`timescale 1ns/1ps
module pin_mode_steer_bench;
  localparam int DW = 8;
  localparam int AW = 14;

  logic clk = 0, rstN = 0, holdReset = 0;
  logic [2:0] modePins = 3'd7;
  logic [2:0] modeCode;
  logic [7:0] isolateOneHot;
  logic padInvIn = 0, padInvOut, clkEcho;
  logic [DW-1:0] dataPins = '0;
  logic [AW-DW-1:0] spareAddrPins = '0;
  logic memWritePin = 0;
  logic [1:0][AW-1:0] bufAddrInt = '0;
  logic [1:0] bufWeInt = '0;
  logic [1:0][DW-1:0] bufWrDataInt = '0;
  logic [1:0][AW-1:0] bufAddr;
  logic [1:0] bufWe;
  logic [1:0][DW-1:0] bufWrData;
  logic [DW-1:0] busIn = '0, busOut, coreOutPixel = '0, workPixel = '0, coreInPixel;
  logic busOe, coreOutValid = 0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pin_mode_steer #(.DW(DW), .AW(AW)) u_pin_mode_steer (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk);
    holdReset = 1; modePins = m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    holdReset = 0;
    #1;
    check(modeCode == m, "R2 mode adopted", modeCode, m);
  endtask

  task automatic t_reset();
    #1;
    check(modeCode == 3'd7, "R1 reset mode", modeCode, 7);
    check(isolateOneHot == 8'h80, "R1 reset onehot", isolateOneHot, 8'h80);
    coreOutValid = 1; #1;
    check(busOe == 0, "R1 reset bus idle", busOe, 0);
    coreOutValid = 0;
  endtask

  task automatic t_latency();
    @(negedge clk);
    holdReset = 1; modePins = 3'd4;
    @(posedge clk); @(posedge clk); #1;
    check(modeCode == 3'd7, "R2 not early", modeCode, 7);
    @(posedge clk); #1;
    check(modeCode == 3'd4, "R2 third edge", modeCode, 4);
    @(negedge clk); holdReset = 0;
  endtask

  task automatic t_ignore();
    @(negedge clk);
    modePins = 3'd1;
    repeat (6) @(posedge clk);
    @(negedge clk); #1;
    check(modeCode == 3'd4, "R3 pins ignored without hold", modeCode, 4);
  endtask

  task automatic t_onehot();
    for (int m = 0; m < 8; m++) begin
      setMode(m[2:0]);
      check(isolateOneHot == (8'h1 << m), "R4 onehot", isolateOneHot, 8'h1 << m);
    end
  endtask

  task automatic t_pad();
    setMode(3'd0);
    padInvIn = 1; #1;
    check(padInvOut == 0, "R5 inverter high in", padInvOut, 0);
    padInvIn = 0; #1;
    check(padInvOut == 1, "R5 inverter low in", padInvOut, 1);
    @(posedge clk); #0.5;
    check(clkEcho == 1, "R5 echo high", clkEcho, 1);
    @(negedge clk); #0.5;
    check(clkEcho == 0, "R5 echo low", clkEcho, 0);
    setMode(3'd5);
    padInvIn = 0; #1;
    check(padInvOut == 0, "R5 inverter off", padInvOut, 0);
    @(posedge clk); #0.5;
    check(clkEcho == 0, "R5 echo off", clkEcho, 0);
  endtask

  task automatic t_buffers();
    bufAddrInt[0] = 14'h0123; bufAddrInt[1] = 14'h2345;
    bufWeInt = 2'b10; bufWrDataInt[0] = 8'h11; bufWrDataInt[1] = 8'h22;
    dataPins = 8'hA5; spareAddrPins = 6'h2C; memWritePin = 1;
    setMode(3'd1); #1;
    check(bufAddr[0] == 14'h2CA5, "R6 inbuf pin addr", bufAddr[0], 14'h2CA5);
    check(bufWe[0] == 1, "R6 inbuf pin we", bufWe[0], 1);
    check(bufWrData[0] == 8'hA5, "R6 inbuf pin data", bufWrData[0], 8'hA5);
    check(bufAddr[1] == 14'h2345 && bufWe[1] == 1 && bufWrData[1] == 8'h22,
          "R7 outbuf internal in mode1", bufAddr[1], 14'h2345);
    setMode(3'd2);
    dataPins = 8'h3C; spareAddrPins = 6'h01; memWritePin = 0; #1;
    check(bufAddr[1] == 14'h013C, "R6 outbuf pin addr", bufAddr[1], 14'h013C);
    check(bufWe[1] == 0, "R6 outbuf pin we", bufWe[1], 0);
    check(bufWrData[1] == 8'h3C, "R6 outbuf pin data", bufWrData[1], 8'h3C);
    check(bufAddr[0] == 14'h0123 && bufWe[0] == 0 && bufWrData[0] == 8'h11,
          "R7 inbuf internal in mode2", bufAddr[0], 14'h0123);
    setMode(3'd7); #1;
    check(bufAddr == {14'h2345, 14'h0123}, "R7 full mode addr", bufAddr[0], 14'h0123);
    check(bufWe == 2'b10 && bufWrData == {8'h22, 8'h11}, "R7 full mode we/data", bufWe, 2'b10);
  endtask

  task automatic t_core();
    setMode(3'd3);
    busIn = 8'h5A; workPixel = 8'hC3; coreOutPixel = 8'h77; coreOutValid = 0; #1;
    check(coreInPixel == 8'h5A, "R8 core input from bus", coreInPixel, 8'h5A);
    check(busOe == 0, "R8 bus released on input phase", busOe, 0);
    coreOutValid = 1; #1;
    check(busOe == 1, "R8 bus driven on valid", busOe, 1);
    check(busOut == 8'h77, "R8 bus carries core output", busOut, 8'h77);
    coreOutValid = 0;
    setMode(3'd4);
    coreOutValid = 1; #1;
    check(busOe == 0, "R9 no drive outside core mode", busOe, 0);
    check(coreInPixel == 8'hC3, "R9 core input from memory", coreInPixel, 8'hC3);
    coreOutValid = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rstN = 1;
    #1;
    check(modeCode == 3'd7, "R1 mode after release", modeCode, 7);
    t_latency();
    t_ignore();
    t_onehot();
    t_pad();
    t_buffers();
    t_core();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule